// File: doc/BRIEF.md
# Static Next-PC Predictor

This block chooses the address that the fetch stage of a five-stage pipeline reads next. Each cycle it is given the class of the instruction at the current PC, that instruction's jump target and its fall-through address. It then loads the program counter with the path it predicts. For a return, the target input carries the address from an external return stack. A static policy, fixed by a parameter, picks the predicted path for conditional branches: always taken, never taken, or taken only when the target does not lie above the current PC.

For every conditional branch, the block also records the path it did not predict and carries that address alongside the branch. After a configurable number of cycles the branch reaches execute, where its condition is known. The block then asks the execute stage for the outcome. On a wrong guess it raises a one-cycle flag and provides the recovery address in the same cycle. It cancels the younger conditional branches still in flight and restarts fetch on the correct path.

Top module: `nextpc_predictor`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `pc` is 0, and `resolve_req` and `mispredict` are low.
- R2: Class code 0 (ordinary instruction) loads `pc` with `fetch_fallthru` on the next edge, unless a misprediction is being reported.
- R3: Class codes 2 (jump), 3 (call) and 4 (return) load `pc` with `fetch_target` on the next edge under every policy, unless a misprediction is being reported.
- R4: With POLICY 0 (always taken), class code 1 (conditional branch) loads `pc` with `fetch_target`.
- R5: With POLICY 1 (never taken), class code 1 loads `pc` with `fetch_fallthru`.
- R6: With POLICY 2, class code 1 loads `fetch_target` when the target is less than or equal to the current `pc`, and `fetch_fallthru` otherwise.
- R7: `resolve_req` is high exactly EX_DEPTH cycles (default 2) after a conditional branch was fetched, provided no misprediction cancelled it in between. `ex_taken` is used only in that cycle.
- R8: When `resolve_req` is high and `ex_taken` disagrees with the prediction made for that branch, `mispredict` is high in that same cycle and `redirect_pc` equals the address that was not predicted. Otherwise `mispredict` is low.
- R9: After a cycle with `mispredict` high, `pc` equals the `redirect_pc` of that cycle. The fetch-stage prediction made in that cycle is discarded.
- R10: A misprediction cancels the younger conditional branches, including the one fetched in the same cycle. `resolve_req` is therefore low for the next EX_DEPTH cycles, so `mispredict` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_cls | input | 3 | Class of the instruction at `pc`: 0 other, 1 conditional, 2 jump, 3 call, 4 return |
| fetch_target | input | PC_W | Jump, call or return destination of the fetched instruction |
| fetch_fallthru | input | PC_W | Sequential successor address of the fetched instruction |
| ex_taken | input | 1 | Resolved condition of the branch in execute, valid while `resolve_req` is high |
| pc | output | PC_W | Current fetch address |
| resolve_req | output | 1 | A live conditional branch is in execute |
| mispredict | output | 1 | The resolving branch was predicted wrongly |
| redirect_pc | output | PC_W | Recovery address, valid while `mispredict` is high |

## Verification
Suppose the prediction stored for a branch were corrupted. The fault would appear EX_DEPTH cycles after fetch, as a `mispredict` that is missing or spurious, or as a wrong `redirect_pc`. It would then appear one cycle later as a wrong `pc`. A squash that fails to clear the in-flight stages shows up as `resolve_req` staying high just after a misprediction. That can produce a second `mispredict` back to back. A wrong policy comparison or path select shows up in `pc` on the very next edge. The bench runs the three policies side by side on the same stimulus, so a fault in any one of them shows up as a mismatch against its reference.

// File: rtl/bp_pkg.sv
package bp_pkg;

   typedef enum logic [2:0] {
      CLS_OTHER = 3'd0,
      CLS_COND  = 3'd1,
      CLS_JUMP  = 3'd2,
      CLS_CALL  = 3'd3,
      CLS_RET   = 3'd4
   } instr_cls_e;

   localparam int POL_ALWAYS = 0;
   localparam int POL_NEVER  = 1;
   localparam int POL_BACKWD = 2;

endpackage

// File: rtl/bp_policy.sv
module bp_policy
   import bp_pkg::*;
#(
   parameter int PC_W   = 16,
   parameter int POLICY = POL_BACKWD
) (
   input  logic [2:0]      cls,
   input  logic [PC_W-1:0] cur_pc,
   input  logic [PC_W-1:0] target,
   output logic            is_cond,
   output logic            take
);

   logic uncond;
   logic cond_take;

   assign uncond  = (cls == CLS_JUMP) || (cls == CLS_CALL) || (cls == CLS_RET);
   assign is_cond = (cls == CLS_COND);

   generate
      if (POLICY == POL_ALWAYS) begin : g_always
         assign cond_take = 1'b1;
      end else if (POLICY == POL_NEVER) begin : g_never
         assign cond_take = 1'b0;
      end else begin : g_backwd
         assign cond_take = (target <= cur_pc);
      end
   endgenerate

   assign take = uncond || (is_cond && cond_take);

endmodule

// File: rtl/bp_track.sv
module bp_track #(
   parameter int PC_W   = 16,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            push,
   input  logic            push_pred,
   input  logic [PC_W-1:0] push_alt,
   input  logic            flush,
   output logic            head_valid,
   output logic            head_pred,
   output logic [PC_W-1:0] head_alt
);

   localparam int LAST = STAGES - 1;

   logic            vld [STAGES];
   logic            prd [STAGES];
   logic [PC_W-1:0] alt [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_entry
            always_ff @(posedge clk) begin
               if (rst) begin
                  vld[s] <= 1'b0;
                  prd[s] <= 1'b0;
                  alt[s] <= '0;
               end else begin
                  vld[s] <= push && !flush;
                  prd[s] <= push_pred;
                  alt[s] <= push_alt;
               end
            end
         end else begin : g_shift
            always_ff @(posedge clk) begin
               if (rst) begin
                  vld[s] <= 1'b0;
                  prd[s] <= 1'b0;
                  alt[s] <= '0;
               end else begin
                  vld[s] <= vld[s-1] && !flush;
                  prd[s] <= prd[s-1];
                  alt[s] <= alt[s-1];
               end
            end
         end
      end
   endgenerate

   assign head_valid = vld[LAST];
   assign head_pred  = prd[LAST];
   assign head_alt   = alt[LAST];

endmodule

// File: rtl/nextpc_predictor.sv
module nextpc_predictor
   import bp_pkg::*;
#(
   parameter int PC_W     = 16,
   parameter int POLICY   = POL_BACKWD,
   parameter int EX_DEPTH = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [2:0]      fetch_cls,
   input  logic [PC_W-1:0] fetch_target,
   input  logic [PC_W-1:0] fetch_fallthru,
   input  logic            ex_taken,
   output logic [PC_W-1:0] pc,
   output logic            resolve_req,
   output logic            mispredict,
   output logic [PC_W-1:0] redirect_pc
);

   generate
      if (PC_W < 2) begin : g_bad_width
         $error("nextpc_predictor: PC_W must be at least 2");
      end
      if (POLICY < POL_ALWAYS || POLICY > POL_BACKWD) begin : g_bad_policy
         $error("nextpc_predictor: POLICY must be 0, 1 or 2");
      end
      if (EX_DEPTH < 1) begin : g_bad_depth
         $error("nextpc_predictor: EX_DEPTH must be at least 1");
      end
   endgenerate

   logic            take;
   logic            is_cond;
   logic [PC_W-1:0] pred_next;
   logic [PC_W-1:0] other_path;
   logic            head_valid;
   logic            head_pred;
   logic [PC_W-1:0] head_alt;
   logic [PC_W-1:0] pc_q;

   bp_policy #(.PC_W(PC_W), .POLICY(POLICY)) u_policy (
      .cls     (fetch_cls),
      .cur_pc  (pc_q),
      .target  (fetch_target),
      .is_cond (is_cond),
      .take    (take)
   );

   assign pred_next  = take ? fetch_target   : fetch_fallthru;
   assign other_path = take ? fetch_fallthru : fetch_target;

   bp_track #(.PC_W(PC_W), .STAGES(EX_DEPTH)) u_track (
      .clk        (clk),
      .rst        (rst),
      .push       (is_cond),
      .push_pred  (take),
      .push_alt   (other_path),
      .flush      (mispredict),
      .head_valid (head_valid),
      .head_pred  (head_pred),
      .head_alt   (head_alt)
   );

   assign resolve_req = head_valid;
   assign mispredict  = head_valid && (ex_taken != head_pred);
   assign redirect_pc = head_alt;

   always_ff @(posedge clk) begin
      if (rst)             pc_q <= '0;
      else if (mispredict) pc_q <= head_alt;
      else                 pc_q <= pred_next;
   end

   assign pc = pc_q;

endmodule

// File: rtl/bp_chk.sv
module bp_chk
   import bp_pkg::*;
#(
   parameter int PC_W   = 16,
   parameter int POLICY = POL_BACKWD
) (
   input logic            clk,
   input logic            rst,
   input logic [2:0]      fetch_cls,
   input logic [PC_W-1:0] fetch_target,
   input logic [PC_W-1:0] fetch_fallthru,
   input logic [PC_W-1:0] pc,
   input logic            resolve_req,
   input logic            mispredict,
   input logic [PC_W-1:0] redirect_pc
);

   // R1
   reset_pc_chk: assert property (@(posedge clk) rst |=> (pc == '0) && !resolve_req);

   // R8
   flag_gated_chk: assert property (@(posedge clk) disable iff (rst)
      !resolve_req |-> !mispredict);

   // R9
   redirect_load_chk: assert property (@(posedge clk) disable iff (rst)
      mispredict |=> pc == $past(redirect_pc));

   // R10
   squash_window_chk: assert property (@(posedge clk) disable iff (rst)
      mispredict |=> !resolve_req);

   // R2
   seq_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (fetch_cls == CLS_OTHER) && !mispredict |=> pc == $past(fetch_fallthru));

   // R3
   uncond_follow_chk: assert property (@(posedge clk) disable iff (rst)
      ((fetch_cls == CLS_JUMP) || (fetch_cls == CLS_CALL) || (fetch_cls == CLS_RET))
      && !mispredict |=> pc == $past(fetch_target));

   generate
      if (POLICY == POL_ALWAYS) begin : g_a
         // R4
         cond_taken_chk: assert property (@(posedge clk) disable iff (rst)
            (fetch_cls == CLS_COND) && !mispredict |=> pc == $past(fetch_target));
      end else if (POLICY == POL_NEVER) begin : g_n
         // R5
         cond_fall_chk: assert property (@(posedge clk) disable iff (rst)
            (fetch_cls == CLS_COND) && !mispredict |=> pc == $past(fetch_fallthru));
      end else begin : g_b
         // R6
         cond_dir_chk: assert property (@(posedge clk) disable iff (rst)
            (fetch_cls == CLS_COND) && !mispredict |=>
            pc == (($past(fetch_target) <= $past(pc)) ? $past(fetch_target) : $past(fetch_fallthru)));
      end
   endgenerate

endmodule

bind nextpc_predictor bp_chk #(.PC_W(PC_W), .POLICY(POLICY)) u_chk (
   .clk            (clk),
   .rst            (rst),
   .fetch_cls      (fetch_cls),
   .fetch_target   (fetch_target),
   .fetch_fallthru (fetch_fallthru),
   .pc             (pc),
   .resolve_req    (resolve_req),
   .mispredict     (mispredict),
   .redirect_pc    (redirect_pc)
);

// File: tb/tb_nextpc_predictor.sv
module tb_nextpc_predictor;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [2:0]   cls = 3'd0;
   logic [W-1:0] tgt = '0;
   logic [W-1:0] fth = '0;
   logic         ex  = 1'b0;

   logic [W-1:0] pc_o  [3];
   logic         rr_o  [3];
   logic         mp_o  [3];
   logic [W-1:0] rd_o  [3];

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   nextpc_predictor #(.PC_W(W), .POLICY(2)) dut (
      .clk(clk), .rst(rst), .fetch_cls(cls), .fetch_target(tgt), .fetch_fallthru(fth),
      .ex_taken(ex), .pc(pc_o[2]), .resolve_req(rr_o[2]), .mispredict(mp_o[2]),
      .redirect_pc(rd_o[2]));

   nextpc_predictor #(.PC_W(W), .POLICY(0)) dut_t (
      .clk(clk), .rst(rst), .fetch_cls(cls), .fetch_target(tgt), .fetch_fallthru(fth),
      .ex_taken(ex), .pc(pc_o[0]), .resolve_req(rr_o[0]), .mispredict(mp_o[0]),
      .redirect_pc(rd_o[0]));

   nextpc_predictor #(.PC_W(W), .POLICY(1)) dut_n (
      .clk(clk), .rst(rst), .fetch_cls(cls), .fetch_target(tgt), .fetch_fallthru(fth),
      .ex_taken(ex), .pc(pc_o[1]), .resolve_req(rr_o[1]), .mispredict(mp_o[1]),
      .redirect_pc(rd_o[1]));

   // reference state per policy
   logic [W-1:0] mpc [3];
   logic         v1 [3], p1 [3], v2 [3], p2 [3];
   logic [W-1:0] a1 [3], a2 [3];
   string        ptag [3];
   int           since_mis [3];

   function automatic logic exp_take(int pol, logic [2:0] c, logic [W-1:0] cur, logic [W-1:0] t);
      if (c == 3'd2 || c == 3'd3 || c == 3'd4) return 1'b1;
      if (c != 3'd1) return 1'b0;
      if (pol == 0) return 1'b1;
      if (pol == 1) return 1'b0;
      return t <= cur;
   endfunction

   function automatic string tag_for(int pol, logic [2:0] c);
      if (c == 3'd0) return "R2";
      if (c != 3'd1) return "R3";
      if (pol == 0) return "R4";
      if (pol == 1) return "R5";
      return "R6";
   endfunction

   task automatic chk(string req, int inst, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s inst %0d actual %h expected %h", req, inst, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         chk("R1", i, pc_o[i], '0);
         chk("R1", i, {15'd0, rr_o[i]}, '0);
         chk("R1", i, {15'd0, mp_o[i]}, '0);
         mpc[i] = '0; v1[i] = 0; v2[i] = 0; p1[i] = 0; p2[i] = 0;
         a1[i] = '0; a2[i] = '0; ptag[i] = "R1"; since_mis[i] = 99;
      end
      rst = 1'b0;
      for (int c = 0; c < 3000; c++) begin
         if (c < 40) cls = 3'd1;
         else if (c < 60) cls = 3'd2 + 3'($urandom % 3);
         else if (c < 80) cls = 3'd0;
         else if (c < 120) cls = 3'd1;
         else cls = 3'($urandom % 5);
         fth = W'($urandom);
         tgt = W'($urandom);
         if (c >= 80 && c < 120) tgt = pc_o[2] - W'($urandom % 3);
         if (c < 20) ex = 1'b0;
         else ex = 1'($urandom % 2);
         #1;
         for (int i = 0; i < 3; i++) begin
            logic take, mis;
            chk(ptag[i], i, pc_o[i], mpc[i]);
            mis = v2[i] && (ex != p2[i]);
            chk((since_mis[i] <= 2) ? "R10" : "R7", i, {15'd0, rr_o[i]}, {15'd0, v2[i]});
            chk("R8", i, {15'd0, mp_o[i]}, {15'd0, mis});
            if (mis) chk("R8", i, rd_o[i], a2[i]);
            take = exp_take(i, cls, mpc[i], tgt);
            ptag[i] = mis ? "R9" : tag_for(i, cls);
            since_mis[i] = mis ? 1 : since_mis[i] + 1;
            mpc[i] = mis ? a2[i] : (take ? tgt : fth);
            v2[i] = !mis && v1[i]; p2[i] = p1[i]; a2[i] = a1[i];
            v1[i] = !mis && (cls == 3'd1); p1[i] = take; a1[i] = take ? fth : tgt;
         end
         @(negedge clk);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule